// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Alternating Byte Clocks

The block sits behind a bit-rate sampler and sees one line-coded serial bit on every bit-clock edge. It packs the bits into 10-bit words, least significant bit first, and presents each word on a parallel bus. Two byte clocks at one twentieth of the bit rate go with the bus. They run in antiphase, and their rising edges take turns so that a downstream pair of capture registers latches alternate words. Each rising edge falls five bit times after the word it belongs to appears, which is the middle of that word's valid window.

When alignment is enabled, a matcher looks for the seven-bit comma prefix, in either running-disparity form, twenty bit times ahead of the output window. On a hit, the byte-clock sequence is frozen at its present levels for just the number of bit times needed. The comma word then reaches the bus as a word owned by byte clock B, its rising edge stays centered on it, and a detect flag is raised for that word. No clock period is ever shortened. An alignment that is already correct costs nothing. With alignment disabled, the word boundary never moves.

Top module: `comma_word_deser`

## Requirements
- R1: While reset is held and right after it, `word_o` is zero, `comma_det_o` is low, `bclk_a_o` is low and `bclk_b_o` is high.
- R2: Bit j of `word_o` is the j-th bit received of that word, so bit 0 is the earliest. The newest bit of a word is sampled 21 bit-clock edges before the edge that presents the word. The word holds between presentations.
- R3: Without stretching, the byte clocks are always complementary and each has a period of 20 edges. A new word appears every 10 edges, and the clock that owns it rises 5 edges later. Counting edges from the release of reset, clock A rises on edges 10, 30, 50, … and clock B rises on edges 20, 40, …, so clock A owns the first assembled word.
- R4: A comma is a 7-bit prefix received as 0011111 or as 1100000, in arrival order. Word bits 6..0 therefore read 1111100 or 0000011.
- R5: With `align_en` high, a comma whose last bit is sampled on edge e is presented on edge e+21 as a clock-B word, `comma_det_o` is high, and clock B rises on edge e+26.
- R6: For alignment, both byte clocks hold their levels for 0 to 19 edges and never toggle early. Two rising edges of the same clock are never fewer than 20 edges apart. The largest stretch gives a 39-edge gap.
- R7: A comma that already falls into a clock-B word causes no stretch, and both clock schedules stay as in R3.
- R8: With `align_en` low, a misaligned comma changes neither the clock schedule nor the word boundary, and raises no flag.
- R9: `comma_det_o` goes high only for clock-B words. An aligned comma in a clock-A word leaves it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| align_en | input | 1 | Enables comma-driven word realignment |
| word_o | output | 10 | Parallel word, bit 0 received first |
| comma_det_o | output | 1 | High while the presented word is an aligned comma in a clock-B slot |
| bclk_a_o | output | 1 | Byte clock A, one twentieth of the bit rate |
| bclk_b_o | output | 1 | Byte clock B, antiphase to clock A |

## Verification
The hardest case is the 19-edge stretch. It only occurs when the comma completes in the bit time just before a clock-B word boundary would have fallen, one position short of alignment. The directed stimulus resets the block and then places the comma so that its last bit lands on a chosen edge number. Because the phase after reset is known, each scenario picks the exact phase offset it needs: the largest stretch, a one-edge stretch, an already-aligned comma, and a comma in the clock-A slot. The bench then checks the gap between clock-B rising edges and the edge on which the comma word appears.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  // Seven leading bits of the comma, window bit 0 received first.
  localparam logic [6:0] MARK_FORM_N = 7'b1111100; // arrival order 0011111
  localparam logic [6:0] MARK_FORM_P = 7'b0000011; // arrival order 1100000

  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;

  function automatic logic is_mark(input logic [6:0] lead7);
    return (lead7 == MARK_FORM_N) || (lead7 == MARK_FORM_P);
  endfunction

  // Edges to freeze so that a comma complete at the look-ahead window while
  // the phase is ph reaches the output window exactly at the slot-B boundary
  // (phase w-1 advancing), given a look-ahead of lead bits.
  function automatic int unsigned hold_len(input int unsigned ph,
                                           input int unsigned w,
                                           input int unsigned lead);
    return (ph + lead + 2 * w - (w - 1)) % (2 * w);
  endfunction

  // Level of byte clock A for a phase value; clock B is its complement.
  function automatic logic clk_a_level(input int unsigned ph,
                                       input int unsigned w);
    return (ph >= w / 2) && (ph < w / 2 + w);
  endfunction

endpackage

// File: rtl/cwd_shifter.sv
module cwd_shifter #(
  parameter int W    = 10,
  parameter int LEAD = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_in,
  output logic [W-1:0] win_new,
  output logic [W-1:0] win_old
);
  localparam int DEPTH = LEAD + W;

  logic [DEPTH-1:0] sr_q;

  // Newest bit enters at the top; the bottom W bits form the output window.
  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {ser_in, sr_q[DEPTH-1:1]};
  end

  assign win_new = sr_q[DEPTH-1 -: W];
  assign win_old = sr_q[W-1:0];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sr_q[DEPTH-1] == $past(ser_in)); // R2
endmodule

// File: rtl/cwd_mark_det.sv
module cwd_mark_det #(
  parameter int W = 10
) (
  input  logic [W-1:0] win,
  output logic         hit
);
  import cwd_pkg::*;

  always_comb hit = is_mark(win[6:0]);
endmodule

// File: rtl/cwd_phase.sv
module cwd_phase #(
  parameter int W    = 10,
  parameter int LEAD = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         align_en,
  input  logic                         hit_new,
  output logic [$clog2(2*W)-1:0]       ph_o,
  output logic                         busy_o,
  output logic                         load_a_o,
  output logic                         load_b_o,
  output logic                         bclk_a_o,
  output logic                         bclk_b_o
);
  import cwd_pkg::*;

  localparam int PH      = 2 * W;
  localparam int PHW     = $clog2(PH);
  localparam int PH_INIT = W + W / 2;
  localparam int GW      = PHW + 1;

  logic [PHW-1:0] ph_q, ph_n, cnt_q, cnt_n, k_w;
  logic           busy, start, adv;

  assign k_w   = PHW'(hold_len(32'(ph_q), W, LEAD));
  assign busy  = (cnt_q != '0);
  assign start = align_en && hit_new && !busy && (k_w != '0);
  assign adv   = !busy && !start;

  always_comb begin
    ph_n = ph_q;
    if (adv) ph_n = (ph_q == PHW'(PH - 1)) ? '0 : ph_q + PHW'(1);
    if (start)     cnt_n = k_w - PHW'(1);
    else if (busy) cnt_n = cnt_q - PHW'(1);
    else           cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PHW'(PH_INIT);
      cnt_q    <= '0;
      bclk_a_o <= clk_a_level(32'(PH_INIT), W);
      bclk_b_o <= !clk_a_level(32'(PH_INIT), W);
    end else begin
      ph_q     <= ph_n;
      cnt_q    <= cnt_n;
      bclk_a_o <= clk_a_level(32'(ph_n), W);
      bclk_b_o <= !clk_a_level(32'(ph_n), W);
    end
  end

  assign ph_o     = ph_q;
  assign busy_o   = busy;
  assign load_a_o = adv && (ph_q == PHW'(PH - 1));
  assign load_b_o = adv && (ph_q == PHW'(W - 1));

  // Rising-edge spacing monitor for clock A.
  logic          a_prev_q;
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev_q <= clk_a_level(32'(PH_INIT), W);
      gap_q    <= '0;
    end else begin
      a_prev_q <= bclk_a_o;
      if (bclk_a_o && !a_prev_q)             gap_q <= GW'(1);
      else if (gap_q != '0 && gap_q != '1)   gap_q <= gap_q + GW'(1);
    end
  end

  AST_CLK_OPPOSED: assert property (@(posedge clk) disable iff (rst)
    bclk_a_o != bclk_b_o); // R3
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(bclk_a_o) && $stable(bclk_b_o)); // R6
  AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= PHW'(PH - 2)); // R6
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (bclk_a_o && !a_prev_q && gap_q != '0) |-> gap_q >= GW'(PH)); // R6
endmodule

// File: rtl/cwd_word_reg.sv
module cwd_word_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_a,
  input  logic         load_b,
  input  logic         hit_old,
  input  logic [W-1:0] win_old,
  output logic [W-1:0] word_o,
  output logic         det_o
);
  import cwd_pkg::*;

  slot_e slot_w;
  assign slot_w = load_b ? SLOT_B : SLOT_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      det_o  <= 1'b0;
    end else if (load_a || load_b) begin
      word_o <= win_old;
      det_o  <= (slot_w == SLOT_B) && hit_old;
    end
  end

  AST_WORD_STEADY: assert property (@(posedge clk) disable iff (rst)
    !(load_a || load_b) |=> $stable(word_o)); // R2
  AST_FLAG_IS_MARK: assert property (@(posedge clk) disable iff (rst)
    det_o |-> is_mark(word_o[6:0])); // R4
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_a, load_b})); // R3
endmodule

// File: rtl/comma_word_deser.sv
module comma_word_deser #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              align_en,
  output logic [WORD_W-1:0] word_o,
  output logic              comma_det_o,
  output logic              bclk_a_o,
  output logic              bclk_b_o
);
  localparam int LEAD = 2 * WORD_W;
  localparam int PHW  = $clog2(2 * WORD_W);

  logic [WORD_W-1:0] win_new, win_old;
  logic              hit_new, hit_old;
  logic [PHW-1:0]    ph;
  logic              busy, load_a, load_b;

  cwd_shifter #(.W(WORD_W), .LEAD(LEAD)) u_shift (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .win_new(win_new), .win_old(win_old)
  );

  cwd_mark_det #(.W(WORD_W)) u_det_new (.win(win_new), .hit(hit_new));
  cwd_mark_det #(.W(WORD_W)) u_det_old (.win(win_old), .hit(hit_old));

  cwd_phase #(.W(WORD_W), .LEAD(LEAD)) u_phase (
    .clk(clk), .rst(rst), .align_en(align_en), .hit_new(hit_new),
    .ph_o(ph), .busy_o(busy), .load_a_o(load_a), .load_b_o(load_b),
    .bclk_a_o(bclk_a_o), .bclk_b_o(bclk_b_o)
  );

  cwd_word_reg #(.W(WORD_W)) u_word (
    .clk(clk), .rst(rst), .load_a(load_a), .load_b(load_b),
    .hit_old(hit_old), .win_old(win_old),
    .word_o(word_o), .det_o(comma_det_o)
  );

  AST_FLAG_SLOT_B: assert property (@(posedge clk) disable iff (rst)
    comma_det_o |-> (ph >= PHW'(WORD_W))); // R9
  AST_ALIGNED_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (align_en && hit_new && !busy && ph == PHW'(WORD_W - 1))
      |=> ph == PHW'(WORD_W)); // R7
  AST_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!align_en && !busy) |=> !busy); // R8
  AST_RESET_LEVELS: assert property (@(posedge clk)
    rst |=> (word_o == '0) && !comma_det_o && !bclk_a_o && bclk_b_o); // R1
endmodule

// File: tb/comma_word_deser_tb.sv
module comma_word_deser_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [9:0] MARK_N = 10'b0101111100; // arrival 0011111010
  localparam logic [9:0] MARK_P = 10'b1010000011; // arrival 1100000101

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       align_en = 1'b0;
  logic [9:0] word_o;
  logic       comma_det_o, bclk_a_o, bclk_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int   ecnt;
  logic hist   [0:255];
  logic obs_a  [0:255];
  logic obs_b  [0:255];
  logic obs_d  [0:255];
  logic [9:0] obs_w [0:255];
  logic [15:0] lfsr;

  comma_word_deser u_dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .align_en(align_en),
    .word_o(word_o), .comma_det_o(comma_det_o),
    .bclk_a_o(bclk_a_o), .bclk_b_o(bclk_b_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else begin
      ecnt <= ecnt + 1;
      if (ecnt < 255) hist[ecnt + 1] <= ser_in;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic next_bit(input int mode, input int s, input int n);
    logic b;
    if (mode == 2) begin
      b = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      return b;
    end
    if (n >= s && n < s + 10) return (mode == 0) ? MARK_N[n - s] : MARK_P[n - s];
    return 1'b0;
  endfunction

  function automatic logic [9:0] exp_word(input int load_edge);
    logic [9:0] w;
    for (int j = 0; j < 10; j++) begin
      int idx = load_edge - 30 + j;
      w[j] = (idx >= 1) ? hist[idx] : 1'b0;
    end
    return w;
  endfunction

  function automatic bit rise_a(input int n);
    return n > 0 && obs_a[n] && !obs_a[n-1];
  endfunction
  function automatic bit rise_b(input int n);
    return n > 0 && obs_b[n] && !obs_b[n-1];
  endfunction

  // Reset, then run n_last edges; mode 0/1 inserts a comma starting at edge s.
  task automatic run(input logic en, input int mode, input int s, input int n_last);
    int last_a = -1;
    int last_b = -1;
    rst = 1'b1; ser_in = 1'b0; align_en = en; lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n <= n_last; n++) begin
      if (n > 0) @(negedge clk);
      obs_a[n] = bclk_a_o; obs_b[n] = bclk_b_o;
      obs_d[n] = comma_det_o; obs_w[n] = word_o;
      check(bclk_a_o != bclk_b_o, "R3", "clocks complementary", int'(bclk_a_o), int'(!bclk_b_o));
      if (rise_a(n)) begin
        if (last_a >= 0) check(n - last_a >= 20, "R6", "clock A rise spacing", n - last_a, 20);
        last_a = n;
      end
      if (rise_b(n)) begin
        if (last_b >= 0) check(n - last_b >= 20, "R6", "clock B rise spacing", n - last_b, 20);
        last_b = n;
      end
      ser_in = next_bit(mode, s, n + 1);
    end
  endtask

  task automatic t_reset;
    run(1'b0, 0, 1000, 2);
    check(obs_w[0] == 10'h0, "R1", "word after reset", int'(obs_w[0]), 0);
    check(obs_d[0] == 1'b0, "R1", "flag after reset", int'(obs_d[0]), 0);
    check(obs_a[0] == 1'b0 && obs_b[0] == 1'b1, "R1", "clock levels after reset",
          int'({obs_a[0], obs_b[0]}), 1);
  endtask

  task automatic t_freerun;
    int first = -1;
    run(1'b0, 2, 0, 200);
    for (int n = 1; n <= 200; n++) begin
      if (rise_a(n)) begin
        if (first < 0) first = n;
        check(n % 20 == 10, "R3", "clock A rise edge", n, 10);
        check(obs_w[n] == exp_word(n - 5), "R2", "word under clock A", int'(obs_w[n]), int'(exp_word(n - 5)));
      end
      if (rise_b(n)) begin
        if (first < 0) first = -2;
        check(n % 20 == 0, "R3", "clock B rise edge", n, 0);
        check(obs_w[n] == exp_word(n - 5), "R2", "word under clock B", int'(obs_w[n]), int'(exp_word(n - 5)));
      end
    end
    check(first == 10, "R3", "first rise belongs to clock A", first, 10);
  endtask

  task automatic t_stretch_max; // last comma bit on edge 53 -> 19-edge hold
    int rises = 0;
    run(1'b1, 0, 44, 120);
    check(obs_w[74] == MARK_N && obs_d[74], "R5", "comma word in slot B", int'(obs_w[74]), int'(MARK_N));
    check(!obs_b[78] && obs_b[79], "R5", "clock B rise on comma", int'({obs_b[78], obs_b[79]}), 1);
    for (int n = 41; n <= 78; n++) if (rise_b(n)) rises++;
    check(rises == 0, "R6", "no clock B rise in 39-edge gap", rises, 0);
    check(obs_b[40] && !obs_b[39], "R6", "rise before stretch", int'(obs_b[40]), 1);
    check(!obs_d[84], "R9", "flag drops for next slot A word", int'(obs_d[84]), 0);
  endtask

  task automatic t_stretch_short; // last bit on edge 55 -> 1-edge hold
    run(1'b1, 0, 46, 120);
    check(rise_b(61) && !rise_b(60), "R6", "clock B rise after one-edge hold", int'(rise_b(61)), 1);
    check(obs_w[76] == MARK_N && obs_d[76], "R5", "comma word edge 76", int'(obs_w[76]), int'(MARK_N));
    check(rise_b(81), "R5", "clock B centered on comma", int'(rise_b(81)), 1);
  endtask

  task automatic t_neg_mark; // other disparity, last bit on edge 58
    run(1'b1, 1, 49, 120);
    check(obs_w[79] == MARK_P && obs_d[79], "R4", "negative-form comma aligned", int'(obs_w[79]), int'(MARK_P));
    check(rise_b(84), "R4", "clock B rise for negative form", int'(rise_b(84)), 1);
  endtask

  task automatic t_aligned; // already in slot B, last bit on edge 54
    run(1'b1, 0, 45, 120);
    check(obs_w[75] == MARK_N && obs_d[75], "R7", "aligned comma flagged", int'(obs_w[75]), int'(MARK_N));
    check(rise_b(60) && rise_b(80) && rise_b(100), "R7", "clock B schedule kept", int'(rise_b(80)), 1);
    check(rise_a(70) && rise_a(90), "R7", "clock A schedule kept", int'(rise_a(90)), 1);
  endtask

  task automatic t_disabled; // misaligned comma, alignment off
    int flags = 0;
    int bad = 0;
    run(1'b0, 0, 44, 120);
    for (int n = 1; n <= 120; n++) begin
      if (obs_d[n]) flags++;
      if (rise_b(n) && n % 20 != 0) bad++;
      if (rise_a(n) && n % 20 != 10) bad++;
    end
    check(bad == 0, "R8", "schedule unchanged when disabled", bad, 0);
    check(flags == 0, "R8", "no flag when disabled", flags, 0);
    check(obs_w[75] == exp_word(75), "R8", "boundary unchanged", int'(obs_w[75]), int'(exp_word(75)));
  endtask

  task automatic t_slot_a; // aligned comma in a clock-A word
    run(1'b0, 0, 55, 120);
    check(obs_w[85] == MARK_N, "R9", "comma word in slot A", int'(obs_w[85]), int'(MARK_N));
    check(!obs_d[85], "R9", "no flag for slot A comma", int'(obs_d[85]), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_freerun();
    t_stretch_max();
    t_stretch_short();
    t_neg_mark();
    t_aligned();
    t_disabled();
    t_slot_a();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule